// File: doc/BRIEF.md
# External Interrupt Request Latch

This block serves one active-low external interrupt pin. The pin is brought into the clock domain through a chain of synchronizing flops, and a high-to-low transition of the synchronized value sets a pending-request latch. The latch drives the CPU interrupt request. A mask bit gates that request, but the mask does not change what software reads as the pending flag, so software can poll the flag instead.

A mode bit selects how the request ends. In edge mode, either the CPU's vector-fetch acknowledge strobe or a software write of 1 to the acknowledge field ends it at once. In level mode, a clear that arrives while the pin is still low is held over. The request then ends when the synchronized pin is seen high again, so the clear and the pin release may come in either order.

A debug-break input and a break-clear-enable input control software clears during a break. With the enable low, a software acknowledge made during a break is ignored. With the enable high, the acknowledge clears the latch, and the latch stays clear after the break ends.

Top module: `ext_irq_latch`

## Requirements
- R1: A falling edge on `irq_pin_n` sets the pending flag. With the default two synchronizer stages, the flag shows from the third rising clock edge, counting the first edge at which the low level is sampled.
- R2: In edge mode (mode field, bit 0, equal to 0), a `vec_ack` pulse or a register write with bit 2 set clears the pending flag at the clock edge where it is applied.
- R3: In level mode (bit 0 equal to 1), a clear applied while the synchronized pin is low leaves the flag set. The flag then drops at the third rising edge after the pin returns high.
- R4: In level mode, when the pin has already returned high, the flag stays set until a clear arrives. It then drops at that clear's edge.
- R5: `reg_rdata` bit 3 is the pending flag and is independent of the mask. Bit 2 (acknowledge) always reads 0, bit 1 reads the mask and bit 0 reads the mode.
- R6: `cpu_irq` is high exactly when the pending flag is set and the mask (bit 1) is 0.
- R7: While `dbg_break` is 1 and `brk_clr_en` is 0, a software write of 1 to bit 2 leaves the pending flag unchanged.
- R8: While `dbg_break` is 1 and `brk_clr_en` is 1, a software acknowledge clears the flag, and the flag stays clear after `dbg_break` returns to 0.
- R9: If a new falling edge is detected in the same cycle as a clear, the flag remains set.
- R10: Reset clears the pending flag, the mask and the mode, so `cpu_irq` is 0 even while the pin is held low. No edge is seen after reset unless the pin is first observed high.
- R11: In edge mode, a pin held low after its flag has been cleared does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| reg_wr | input | 1 | Write strobe for the status/control register |
| reg_wdata | input | 4 | Write data: bit 2 acknowledge, bit 1 mask, bit 0 mode |
| reg_rdata | output | 4 | Read data: bit 3 pending, bit 2 zero, bit 1 mask, bit 0 mode |
| vec_ack | input | 1 | CPU vector-fetch acknowledge strobe |
| dbg_break | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allows software acknowledges during a break |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
A pin change reaches the pending flag at the third rising edge. This holds for a new edge and, in level mode, for a pin release that finishes a held-over clear. Register writes, acknowledges and `vec_ack` act at the first rising edge, and `cpu_irq` follows the flag in the same cycle. The bench drives inputs just after a falling edge and advances its reference model at each rising edge. It then compares every output at the next falling edge. The directed checks count these edge delays exactly, so each expected flag change is sampled in the first cycle it is due and also the cycle before.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   localparam int REG_W    = 4;
   localparam int FLD_MODE = 0;
   localparam int FLD_MASK = 1;
   localparam int FLD_ACK  = 2;
   localparam int FLD_PEND = 3;

   typedef struct packed {
      logic mask;
      logic mode;
   } eirq_ctrl_t;

   typedef enum logic [1:0] {
      LS_IDLE  = 2'd0,
      LS_PEND  = 2'd1,
      LS_ARMED = 2'd2
   } eirq_state_e;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/eirq_edge.sv
module eirq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);

   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign fall = lvl_d & ~lvl;

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import eirq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             dbg_break,
   input  logic             brk_clr_en,
   input  logic             pending,
   output eirq_ctrl_t       ctrl,
   output logic             sw_ack,
   output logic [REG_W-1:0] reg_rdata
);

   logic unused_wbits;
   assign unused_wbits = reg_wdata[FLD_PEND];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (reg_wr) begin
         ctrl.mask <= reg_wdata[FLD_MASK];
         ctrl.mode <= reg_wdata[FLD_MODE];
      end
   end

   assign sw_ack = reg_wr & reg_wdata[FLD_ACK] & (~dbg_break | brk_clr_en);

   always_comb begin
      reg_rdata           = '0;
      reg_rdata[FLD_PEND] = pending;
      reg_rdata[FLD_MASK] = ctrl.mask;
      reg_rdata[FLD_MODE] = ctrl.mode;
   end

endmodule

// File: rtl/eirq_latch.sv
module eirq_latch
   import eirq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic clr,
   input  logic level_mode,
   input  logic pin_hi,
   output logic pending,
   output logic armed
);

   eirq_state_e st, st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         LS_IDLE: begin
            if (fall) st_nx = LS_PEND;
         end
         LS_PEND: begin
            if (fall)                         st_nx = LS_PEND;
            else if (clr && (!level_mode || pin_hi)) st_nx = LS_IDLE;
            else if (clr)                     st_nx = LS_ARMED;
         end
         LS_ARMED: begin
            if (fall)        st_nx = LS_PEND;
            else if (pin_hi) st_nx = LS_IDLE;
         end
         default: st_nx = LS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= LS_IDLE;
      else        st <= st_nx;
   end

   assign pending = (st != LS_IDLE);
   assign armed   = (st == LS_ARMED);

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
   import eirq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_pin_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             vec_ack,
   input  logic             dbg_break,
   input  logic             brk_clr_en,
   output logic             cpu_irq
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ext_irq_latch: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       pin_sync;
   logic       fall_evt;
   logic       sw_ack;
   logic       pending;
   logic       clr_armed;
   eirq_ctrl_t ctrl;

   eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_pin_n),
      .q     (pin_sync)
   );

   eirq_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (pin_sync),
      .fall  (fall_evt)
   );

   eirq_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .dbg_break  (dbg_break),
      .brk_clr_en (brk_clr_en),
      .pending    (pending),
      .ctrl       (ctrl),
      .sw_ack     (sw_ack),
      .reg_rdata  (reg_rdata)
   );

   eirq_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall       (fall_evt),
      .clr        (sw_ack | vec_ack),
      .level_mode (ctrl.mode),
      .pin_hi     (pin_sync),
      .pending    (pending),
      .armed      (clr_armed)
   );

   assign cpu_irq = pending & ~ctrl.mask;

endmodule

module eirq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vec_ack,
   input logic       dbg_break,
   input logic       brk_clr_en,
   input logic [3:0] reg_rdata,
   input logic       cpu_irq,
   input logic       fall,
   input logic       pin_hi,
   input logic       armed
);

   assert_mask_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[1] |-> !cpu_irq);

   assert_ack_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[2] == 1'b0);

   assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> reg_rdata[3]);

   assert_break_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[3] && dbg_break && !brk_clr_en && !vec_ack && !armed) |=> reg_rdata[3]);

   assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[0] && reg_rdata[3] && !pin_hi) |=> reg_rdata[3]);

   assert_edge_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[0] && !armed && vec_ack && !fall) |=> !reg_rdata[3]);

endmodule

bind ext_irq_latch eirq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vec_ack    (vec_ack),
   .dbg_break  (dbg_break),
   .brk_clr_en (brk_clr_en),
   .reg_rdata  (reg_rdata),
   .cpu_irq    (cpu_irq),
   .fall       (fall_evt),
   .pin_hi     (pin_sync),
   .armed      (clr_armed)
);

// File: tb/sim_ext_irq_latch.sv
`timescale 1ns/1ps
module sim_ext_irq_latch;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b1;
   logic       wr = 1'b0;
   logic [3:0] wd = 4'h0;
   logic       vack = 1'b0;
   logic       brk = 1'b0;
   logic       bce = 1'b0;
   logic [3:0] rd;
   logic       irq;

   int    tests = 0;
   int    fails = 0;
   bit    done = 0;
   string cur_req = "R10";

   // behavioural reference state
   bit mq[$];
   bit m_pend, m_wait, m_mask, m_mode;

   always #2 clk = ~clk;

   ext_irq_latch #(.SYNC_STAGES(SYNC)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_pin_n  (pin),
      .reg_wr     (wr),
      .reg_wdata  (wd),
      .reg_rdata  (rd),
      .vec_ack    (vack),
      .dbg_break  (brk),
      .brk_clr_en (bce),
      .cpu_irq    (irq)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         mq = {};
         for (int i = 0; i <= SYNC; i++) mq.push_back(1'b0);
         m_pend = 0; m_wait = 0; m_mask = 0; m_mode = 0;
      end else begin
         bit hi, prev, edge_seen, clear;
         hi        = mq[SYNC-1];
         prev      = mq[SYNC];
         edge_seen = prev && !hi;
         clear     = vack || (wr && wd[2] && (!brk || bce));
         if (edge_seen) begin
            m_pend = 1; m_wait = 0;
         end else if (m_wait) begin
            if (hi) begin m_pend = 0; m_wait = 0; end
         end else if (m_pend && clear) begin
            if (!m_mode || hi) m_pend = 0;
            else               m_wait = 1;
         end
         if (wr) begin m_mask = wd[1]; m_mode = wd[0]; end
         mq.push_front(pin);
         void'(mq.pop_back());
      end
   end

   task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      chk(cur_req, {irq, rd}, {m_pend & ~m_mask, m_pend, 1'b0, m_mask, m_mode});
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wreg(logic [3:0] v);
      wr = 1'b1; wd = v;
      step();
      wr = 1'b0; wd = 4'h0;
   endtask

   task automatic vpulse();
      vack = 1'b1;
      step();
      vack = 1'b0;
   endtask

   initial begin
      // R10: reset state
      steps(3);
      chk("R10", {irq, rd}, 5'h00);
      rst_n = 1'b1;
      steps(2);

      // R1: falling edge latency, R6 request out
      cur_req = "R1";
      pin = 1'b0;
      steps(2);
      chk("R1", {irq, rd}, 5'h00);
      step();
      chk("R1", {irq, rd}, 5'h18);
      chk("R6", {irq, rd}, 5'h18);

      // R2: software clear in edge mode; R11: low pin does not re-set
      cur_req = "R2";
      wreg(4'b0100);
      chk("R2", {irq, rd}, 5'h00);
      cur_req = "R11";
      steps(5);
      chk("R11", {irq, rd}, 5'h00);
      pin = 1'b1;
      steps(4);

      // R6 mask gating, R5 flag readable while masked
      cur_req = "R6";
      wreg(4'b0010);
      chk("R6", {irq, rd}, 5'h02);
      pin = 1'b0;
      steps(3);
      chk("R6", {irq, rd}, 5'h0A);
      chk("R5", {1'b0, rd}, 5'h0A);
      cur_req = "R2";
      vpulse();
      chk("R2", {irq, rd}, 5'h02);
      pin = 1'b1;
      steps(4);
      wreg(4'b0000);

      // R3: level mode, clear before pin release
      cur_req = "R3";
      wreg(4'b0001);
      pin = 1'b0;
      steps(3);
      chk("R3", {irq, rd}, 5'h19);
      vpulse();
      chk("R3", {irq, rd}, 5'h19);
      steps(5);
      chk("R3", {irq, rd}, 5'h19);
      pin = 1'b1;
      steps(2);
      chk("R3", {irq, rd}, 5'h19);
      step();
      chk("R3", {irq, rd}, 5'h01);

      // R4: level mode, pin release before clear
      cur_req = "R4";
      pin = 1'b0;
      steps(3);
      pin = 1'b1;
      steps(4);
      chk("R4", {irq, rd}, 5'h19);
      wreg(4'b0101);
      chk("R4", {irq, rd}, 5'h01);

      // R7 / R8: break gating of software clear
      cur_req = "R7";
      wreg(4'b0000);
      pin = 1'b0;
      steps(3);
      pin = 1'b1;
      steps(3);
      brk = 1'b1; bce = 1'b0;
      wreg(4'b0100);
      chk("R7", {irq, rd}, 5'h18);
      cur_req = "R8";
      bce = 1'b1;
      wreg(4'b0100);
      chk("R8", {irq, rd}, 5'h00);
      brk = 1'b0; bce = 1'b0;
      steps(3);
      chk("R8", {irq, rd}, 5'h00);

      // R9: edge and clear in the same cycle
      cur_req = "R9";
      pin = 1'b0;
      steps(3);
      pin = 1'b1;
      steps(3);
      pin = 1'b0;
      steps(2);
      vpulse();
      chk("R9", {irq, rd}, 5'h18);
      step();
      chk("R9", {irq, rd}, 5'h18);
      pin = 1'b1;
      vpulse();
      chk("R9", {irq, rd}, 5'h00);
      steps(3);

      // R10: reset with pin held low in level mode
      cur_req = "R10";
      wreg(4'b0001);
      pin = 1'b0;
      steps(3);
      chk("R10", {irq, rd}, 5'h19);
      rst_n = 1'b0;
      step();
      chk("R10", {irq, rd}, 5'h00);
      rst_n = 1'b1;
      steps(4);
      chk("R10", {irq, rd}, 5'h00);
      pin = 1'b1;
      steps(3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule